// File: doc/BRIEF.md
# Serial Bus PHY Control Register Block

This block is the small register file that a link-layer controller sees when it talks to a multi-port serial bus physical layer. It has a synchronous port with an address, write data, a write strobe and registered read data. It holds the gap count, the request to start a bus reset, the root hold-off bit, the root and initiator flags, the node's physical ID and two sticky interrupts. It also reports a set of fixed capability fields.

The arbitration logic feeds the block with single-cycle event pulses: bus reset (with a flag that tells whether this node caused it), root decision, tree-ID loop timeout, self-ID completion (with the new physical ID), and a sent or received configuration packet that carries a gap count. The cable power pin is sampled as a level.

Two rules set this block apart. First, the gap count returns to its maximum after two bus resets in a row with no gap-count update between them. Second, the power interrupt cannot be cleared while the power input stays low.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After reset the gap count is 3Fh and the IBR request, root hold-off, root, initiator, physical ID and both interrupts are 0. Read data shows the state as of the clock edge at which `addr` is sampled, one cycle after the address is applied.
- R2: A write to address 1 loads gap count from bits 5:0, root hold-off from bit 6 and the initiate-bus-reset request from bit 7. A read of address 1 returns the same layout.
- R3: A configuration packet pulse (`cfg_valid`) loads the gap count from `cfg_gap`. If a register write to address 1 happens in the same cycle, the write wins.
- R4: A second bus reset with no gap-count update since the previous bus reset sets the gap count to 3Fh. An update in between prevents this. An update in the same cycle as a bus reset also counts as an update, and that bus reset is then not counted.
- R5: `ibr_request` follows the IBR bit. A bus reset clears it, and the clear wins over a write in the same cycle.
- R6: `root_found` sets the root flag (address 0 bit 1). A bus reset clears it, and the clear wins over `root_found` in the same cycle.
- R7: Root hold-off keeps its value across bus resets.
- R8: On each bus reset the initiator flag (address 3 bit 7) loads `reset_local`.
- R9: Address 0 bit 0 and address 3 bit 6 show `cable_pwr_ok`.
- R10: The power interrupt (address 3 bit 1) sets on every cycle that `cable_pwr_ok` is low. Writing 0 to that bit clears it only while power is good. Writing 1 has no effect.
- R11: The loop interrupt (address 3 bit 0) sets on `loop_timeout`. Writing 0 to that bit clears it. Writing 1 has no effect.
- R12: `selfid_done` loads the physical ID from `selfid_id` into address 0 bits 7:2, and `status_xfer` is high for exactly the next cycle.
- R13: Address 2 reads the constant 34h (ports 0011b in bits 7:4, speed 01b in bits 3:2, revision 00b in bits 1:0), and writes to it are ignored. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | GAP_W+2 | Write data |
| rd_data | output | GAP_W+2 | Registered read data |
| bus_reset | input | 1 | Bus reset event pulse |
| reset_local | input | 1 | The current bus reset was started by this node |
| root_found | input | 1 | Tree-ID picked this node as root |
| loop_timeout | input | 1 | Tree-ID waited too long |
| selfid_done | input | 1 | Self-ID phase completed |
| selfid_id | input | ID_W | Physical ID assigned during self-ID |
| cfg_valid | input | 1 | Configuration packet seen |
| cfg_gap | input | GAP_W | Gap count carried by the packet |
| cable_pwr_ok | input | 1 | Cable power status pin, 1 = good |
| ibr_request | output | 1 | Request to start a bus reset |
| gap_count | output | GAP_W | Current gap count |
| root_holdoff | output | 1 | Try to become root at the next bus reset |
| status_xfer | output | 1 | One-cycle request to send register 0 to the link |

## Verification
The bench builds the block with the default values ADDR_W=3, ID_W=6 and GAP_W=6. This gives an 8-bit register word, so every field position named in the requirements is reached and the fallback value is exactly 3Fh. The three-bit address also lets the bench probe the unused addresses 4 to 7. The bench covers same-cycle collisions: a write against a configuration packet, a gap update against a bus reset, a bus reset against an IBR write or a root decision, and a clear request against low power.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
  // register addresses
  localparam int REG_STAT  = 0;
  localparam int REG_CTRL  = 1;
  localparam int REG_IDENT = 2;
  localparam int REG_INT   = 3;
  // fixed capability codes
  localparam logic [3:0] PORTS_CODE = 4'b0011;
  localparam logic [1:0] SPEED_CODE = 2'b01;
  localparam logic [1:0] REV_CODE   = 2'b00;
  // sticky interrupt indices
  localparam int IRQ_LOOP = 0;
  localparam int IRQ_PWR  = 1;
  localparam int NUM_IRQ  = 2;
endpackage

// File: rtl/gap_tracker.sv
module gap_tracker #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_upd,
  input  logic [GAP_W-1:0] wr_gap,
  input  logic             cfg_upd,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             bus_reset,
  output logic [GAP_W-1:0] gap_o
);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic reset_seen;  // one bus reset seen since the last update

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_o      <= GAP_MAX;
      reset_seen <= 1'b0;
    end else if (wr_upd) begin
      gap_o      <= wr_gap;
      reset_seen <= 1'b0;
    end else if (cfg_upd) begin
      gap_o      <= cfg_gap;
      reset_seen <= 1'b0;
    end else if (bus_reset) begin
      if (reset_seen) gap_o <= GAP_MAX;
      reset_seen <= 1'b1;
    end
  end

  // R4
  fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_seen && bus_reset && !wr_upd && !cfg_upd) |=> (gap_o == GAP_MAX));

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_upd && !wr_upd) |=> (gap_o == $past(cfg_gap)));
endmodule

// File: rtl/sticky_irq.sv
module sticky_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  // R10 R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o);
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int ID_W   = 6,
  parameter int GAP_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [GAP_W+1:0]   wr_data,
  output logic [GAP_W+1:0]   rd_data,
  input  logic               bus_reset,
  input  logic               reset_local,
  input  logic               root_found,
  input  logic               loop_timeout,
  input  logic               selfid_done,
  input  logic [ID_W-1:0]    selfid_id,
  input  logic               cfg_valid,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               cable_pwr_ok,
  output logic               ibr_request,
  output logic [GAP_W-1:0]   gap_count,
  output logic               root_holdoff,
  output logic               status_xfer
);
  localparam int DATA_W = GAP_W + 2;

  logic wr_ctrl, wr_int;
  assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign wr_int  = wr_en && (addr == ADDR_W'(REG_INT));

  // gap count with consecutive-reset fallback
  gap_tracker #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst),
    .wr_upd(wr_ctrl), .wr_gap(wr_data[GAP_W-1:0]),
    .cfg_upd(cfg_valid), .cfg_gap(cfg_gap),
    .bus_reset(bus_reset), .gap_o(gap_count)
  );

  // sticky interrupts
  logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_q;
  assign irq_set[IRQ_LOOP] = loop_timeout;
  assign irq_set[IRQ_PWR]  = !cable_pwr_ok;
  assign irq_clr[IRQ_LOOP] = wr_int && !wr_data[IRQ_LOOP];
  assign irq_clr[IRQ_PWR]  = wr_int && !wr_data[IRQ_PWR];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    sticky_irq u_irq (
      .clk(clk), .rst(rst),
      .set_i(irq_set[i]), .clr_i(irq_clr[i]), .irq_o(irq_q[i])
    );
  end

  // control and status flags
  logic            root_q, init_q;
  logic [ID_W-1:0] phy_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibr_request  <= 1'b0;
      root_holdoff <= 1'b0;
      root_q       <= 1'b0;
      init_q       <= 1'b0;
      phy_id       <= '0;
      status_xfer  <= 1'b0;
    end else begin
      if (bus_reset)    ibr_request <= 1'b0;
      else if (wr_ctrl) ibr_request <= wr_data[GAP_W+1];
      if (wr_ctrl) root_holdoff <= wr_data[GAP_W];
      if (bus_reset)       root_q <= 1'b0;
      else if (root_found) root_q <= 1'b1;
      if (bus_reset) init_q <= reset_local;
      if (selfid_done) phy_id <= selfid_id;
      status_xfer <= selfid_done;
    end
  end

  // registered read mux
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(REG_STAT):  rd_next = DATA_W'({phy_id, root_q, cable_pwr_ok});
      ADDR_W'(REG_CTRL):  rd_next = {ibr_request, root_holdoff, gap_count};
      ADDR_W'(REG_IDENT): rd_next = DATA_W'({PORTS_CODE, SPEED_CODE, REV_CODE});
      ADDR_W'(REG_INT): begin
        rd_next[DATA_W-1] = init_q;
        rd_next[DATA_W-2] = cable_pwr_ok;
        rd_next[IRQ_PWR]  = irq_q[IRQ_PWR];
        rd_next[IRQ_LOOP] = irq_q[IRQ_LOOP];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R5
  ibr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !ibr_request);

  // R6
  root_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !root_q);

  // R7
  holdoff_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && !wr_ctrl) |=> $stable(root_holdoff));

  // R12
  selfid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    selfid_done |=> (status_xfer && phy_id == $past(selfid_id)));
endmodule

// File: tb/phy_ctrl_regs_test.sv
module phy_ctrl_regs_test;
  logic       clk = 0, rst = 1;
  logic [2:0] addr = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic       bus_reset = 0, reset_local = 0, root_found = 0, loop_timeout = 0;
  logic       selfid_done = 0, cfg_valid = 0, cable_pwr_ok = 1;
  logic [5:0] selfid_id = '0, cfg_gap = '0, gap_count;
  logic       ibr_request, root_holdoff, status_xfer;
  int errors = 0, checks = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  phy_ctrl_regs uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk) addr = a;
    @(negedge clk) d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk) begin addr = a; wr_data = d; wr_en = 1; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic breset(input logic local_i);
    @(negedge clk) begin bus_reset = 1; reset_local = local_i; end
    @(negedge clk) begin bus_reset = 0; reset_local = 0; end
  endtask

  task automatic cfg(input logic [5:0] g);
    @(negedge clk) begin cfg_valid = 1; cfg_gap = g; end
    @(negedge clk) cfg_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 gap after reset", gap_count, 6'h3F);
    check("R1 ibr after reset", ibr_request, 0);
    rd(1, v); check("R1 ctrl reg", v, 8'h3F);
    rd(0, v); check("R1 stat reg", v, 8'h01);
    rd(3, v); check("R1 int reg", v, 8'h40);
  endtask

  task automatic t_write_ident;
    wr(1, 8'h4A);
    rd(1, v); check("R2 ctrl readback", v, 8'h4A);
    check("R2 gap port", gap_count, 6'h0A);
    check("R2 holdoff port", root_holdoff, 1);
    wr(2, 8'hFF);
    rd(2, v); check("R13 ident const", v, 8'h34);
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v); check("R13 unused addr", v, 0);
    end
  endtask

  task automatic t_cfg;
    cfg(6'h15);
    check("R3 cfg load", gap_count, 6'h15);
    @(negedge clk) begin addr = 1; wr_data = 8'h47; wr_en = 1; cfg_valid = 1; cfg_gap = 6'h20; end
    @(negedge clk) begin wr_en = 0; cfg_valid = 0; end
    check("R3 write wins", gap_count, 6'h07);
  endtask

  task automatic t_fallback;
    breset(0); check("R4 first reset keeps", gap_count, 6'h07);
    breset(0); check("R4 second reset falls back", gap_count, 6'h3F);
    check("R7 holdoff across resets", root_holdoff, 1);
    wr(1, 8'h50); breset(0); cfg(6'h11); breset(0);
    check("R4 cfg between resets", gap_count, 6'h11);
    breset(0); check("R4 fallback after cfg", gap_count, 6'h3F);
    breset(0);
    @(negedge clk) begin addr = 1; wr_data = 8'h52; wr_en = 1; bus_reset = 1; end
    @(negedge clk) begin wr_en = 0; bus_reset = 0; end
    breset(0); check("R4 same-cycle update counts", gap_count, 6'h12);
    breset(0); check("R4 then falls back", gap_count, 6'h3F);
  endtask

  task automatic t_ibr_root;
    wr(1, 8'hD2); check("R5 ibr set", ibr_request, 1);
    breset(0); check("R5 ibr cleared", ibr_request, 0);
    @(negedge clk) begin addr = 1; wr_data = 8'hD2; wr_en = 1; bus_reset = 1; end
    @(negedge clk) begin wr_en = 0; bus_reset = 0; end
    check("R5 reset beats write", ibr_request, 0);
    @(negedge clk) root_found = 1;
    @(negedge clk) root_found = 0;
    rd(0, v); check("R6 root set", v[1], 1);
    breset(0); rd(0, v); check("R6 root cleared", v[1], 0);
    @(negedge clk) begin root_found = 1; bus_reset = 1; end
    @(negedge clk) begin root_found = 0; bus_reset = 0; end
    rd(0, v); check("R6 reset beats root", v[1], 0);
    check("R7 holdoff kept", root_holdoff, 1);
  endtask

  task automatic t_initiator;
    breset(1); rd(3, v); check("R8 initiator set", v[7], 1);
    breset(0); rd(3, v); check("R8 initiator clear", v[7], 0);
  endtask

  task automatic t_pwr;
    @(negedge clk) cable_pwr_ok = 0;
    rd(0, v); check("R9 stat pwr low", v[0], 0);
    rd(3, v); check("R9 int pwr low", v[6], 0);
    check("R10 pwr irq set", v[1], 1);
    wr(3, 8'h00); rd(3, v); check("R10 no clear while low", v[1], 1);
    @(negedge clk) cable_pwr_ok = 1;
    rd(3, v); check("R9 int pwr good", v[6], 1);
    wr(3, 8'hFF); rd(3, v); check("R10 write 1 no effect", v[1], 1);
    wr(3, 8'h01); rd(3, v); check("R10 clear when good", v[1], 0);
  endtask

  task automatic t_loop;
    @(negedge clk) loop_timeout = 1;
    @(negedge clk) loop_timeout = 0;
    rd(3, v); check("R11 loop set", v[0], 1);
    wr(3, 8'hFF); rd(3, v); check("R11 write 1 no effect", v[0], 1);
    wr(3, 8'h02); rd(3, v); check("R11 loop cleared", v[0], 0);
  endtask

  task automatic t_selfid;
    @(negedge clk) begin selfid_done = 1; selfid_id = 6'h2B; end
    @(negedge clk) begin selfid_done = 0; check("R12 strobe high", status_xfer, 1); end
    @(negedge clk) check("R12 strobe one cycle", status_xfer, 0);
    rd(0, v); check("R12 phy id", v[7:2], 6'h2B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write_ident();
    t_cfg();
    t_fallback();
    t_ibr_root();
    t_initiator();
    t_pwr();
    t_loop();
    t_selfid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule